// File: doc/BRIEF.md
# Transactional FIFO with commit and abort

This block is a single-clock FIFO with a valid/ready handshake on its write port and on its read port. Either port can run in transactional mode. On the write side, accepted words stay hidden from the reader until the writer commits them, and an abort pulse throws away everything not yet committed. On the read side, words handed out stay in storage until the reader commits them, and an abort pulse rewinds the reader so that the same words come out again in the same order.

Each side keeps two pointers: a working pointer that moves with every transfer and a committed pointer that only moves on commit. The writer sees free space measured against the reader's committed pointer. The reader sees data measured against the writer's committed pointer. Both sides report a usage count. Transactional behaviour is chosen per side by a parameter; a side with it switched off commits on every transfer. Storage is a register array with a zero-latency read, so the word at the head of the read side is on `rd_data` while `rd_valid` is high. The depth must be a power of two of at least 2.

Top module: `txn_fifo`

## Requirements
- R1: After a clock edge with `rst_n` low, and once `rst_n` is high again with no transfer made, `rd_valid` is 0, `wr_ready` is 1, and both `wr_usage` and `rd_usage` are 0.
- R2: A word moves on a port only on a clock edge where valid and ready are both high; words come out in the order they were accepted; `wr_ready` is low exactly when `wr_usage` equals DEPTH, and `wr_usage` never exceeds DEPTH.
- R3: With write transactions enabled, words accepted while `wr_commit` is low raise `wr_usage` but not `rd_usage`, and `rd_valid` stays low if no committed word is waiting.
- R4: With write transactions enabled, a cycle with `wr_commit` high commits every speculative word plus the word accepted in that same cycle; from the next cycle they are counted in `rd_usage` and readable in order.
- R5: With write transactions enabled, a cycle with `wr_abort` high discards every uncommitted word, including any word offered in that cycle and regardless of `wr_commit`; `wr_usage` falls back to the committed occupancy and `wr_ready` rises if space results.
- R6: With read transactions enabled, words read while `rd_commit` is low do not lower `wr_usage`; once all words are consumed but uncommitted, `rd_valid` is low and, if the FIFO was full, `wr_ready` stays low.
- R7: With read transactions enabled, a cycle with `rd_abort` high returns the reader to its last committed position, even when a read transfer is offered in that cycle; `rd_usage` is restored and the uncommitted words are delivered again in their original order.
- R8: With read transactions enabled, a cycle with `rd_commit` high frees every word consumed so far, including one read in that same cycle; `wr_usage` drops by that amount on the next cycle and `wr_ready` rises.
- R9: `wr_usage` counts words accepted and not yet freed by a read commit; `rd_usage` counts committed words not yet read; both are ceil(log2(DEPTH+1)) bits wide and `rd_valid` is high exactly when `rd_usage` is non-zero.
- R10: On a side whose transaction parameter is 0, every transfer commits at once and that side's commit and abort inputs have no effect.
- R11: While `rd_valid` is high and `rd_ready` is low with no read abort, `rd_valid` stays high and `rd_data` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Writer offers a word |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_data | input | DATA_W | Word offered by the writer |
| wr_commit | input | 1 | Commit all speculative writes, including this cycle's |
| wr_abort | input | 1 | Drop all uncommitted writes |
| wr_usage | output | ceil(log2(DEPTH+1)) | Entries held from the writer's view |
| rd_valid | output | 1 | A committed word is at the head |
| rd_ready | input | 1 | Reader takes the head word |
| rd_data | output | DATA_W | Head word |
| rd_commit | input | 1 | Free all words read so far, including this cycle's |
| rd_abort | input | 1 | Rewind the reader to its committed position |
| rd_usage | output | ceil(log2(DEPTH+1)) | Committed words not yet read |

## Verification
An abort and a commit, or an abort and a transfer, can arrive on the same port in the same cycle. The bench provokes both: a write cycle with valid, commit and abort all high, and a read cycle with ready and abort high while a word is at the head. It judges the result by the usage counts on the following cycle and by which word `rd_data` shows next. The dropped write must not appear, and the rewound read must present the first uncommitted word again.

// File: rtl/txn_fifo_pkg.sv
// Shared types for the transactional FIFO.
// Assumes nothing beyond a single clock domain.
package txn_fifo_pkg;

    // Next-state choice for a working pointer.
    typedef enum logic [1:0] {
        PTR_HOLD     = 2'd0,
        PTR_STEP     = 2'd1,
        PTR_ROLLBACK = 2'd2
    } ptr_op_e;

endpackage

// File: rtl/txn_fifo_ptr_pair.sv
// Working/committed pointer pair for one side of the FIFO.
// The working pointer advances on each transfer; the committed pointer
// catches up on commit. Abort rolls the working pointer back and wins over
// commit and transfer. With TXN_EN = 0 both pointers move together and the
// commit and abort inputs are ignored. Assumes the caller only raises
// step_i when a transfer really happens.
module txn_fifo_ptr_pair
    import txn_fifo_pkg::*;
#(
    parameter int PW     = 5,
    parameter bit TXN_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          commit_i,
    input  logic          abort_i,
    output logic [PW-1:0] spec_o,
    output logic [PW-1:0] cmt_o
);

    logic [PW-1:0] spec_q, spec_d;
    logic [PW-1:0] cmt_q, cmt_d;
    ptr_op_e       op;

    // Select what the working pointer does this cycle.
    always_comb begin
        if (TXN_EN && abort_i) begin
            op = PTR_ROLLBACK;
        end else if (step_i) begin
            op = PTR_STEP;
        end else begin
            op = PTR_HOLD;
        end
    end

    // Working pointer next value.
    always_comb begin
        case (op)
            PTR_STEP:     spec_d = spec_q + PW'(1);
            PTR_ROLLBACK: spec_d = cmt_q;
            default:      spec_d = spec_q;
        endcase
    end

    generate
        if (TXN_EN) begin : g_txn
            // Committed pointer follows the working pointer only on commit.
            always_comb begin
                if (commit_i && !abort_i) begin
                    cmt_d = spec_d;
                end else begin
                    cmt_d = cmt_q;
                end
            end
        end else begin : g_plain
            logic unused_commit;
            assign unused_commit = commit_i;
            // Every transfer commits implicitly.
            always_comb begin
                cmt_d = spec_d;
            end
        end
    endgenerate

    // Pointer registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= '0;
            cmt_q  <= '0;
        end else begin
            spec_q <= spec_d;
            cmt_q  <= cmt_d;
        end
    end

    assign spec_o = spec_q;
    assign cmt_o  = cmt_q;

endmodule

// File: rtl/txn_fifo_store.sv
// Register-array storage with one write port and one zero-latency read port.
// Assumes the controller never writes the slot currently being read.
module txn_fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            // Load entry i when the write address selects it.
            always_ff @(posedge clk) begin
                if (we && (waddr == AW'(i))) begin
                    slot[i] <= wdata;
                end
            end
        end
    endgenerate

    // Present the addressed entry.
    always_comb begin
        rdata = slot[raddr];
    end

endmodule

// File: rtl/txn_fifo.sv
// Transactional single-clock FIFO, top level.
// The writer's free space is measured against the reader's committed
// pointer; the reader's data is measured against the writer's committed
// pointer. Pointers carry one wrap bit. Assumes DEPTH is a power of two,
// at least 2. Outputs depend only on registers, never on inputs.
module txn_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter bit WR_TXN = 1'b1,
    parameter bit RD_TXN = 1'b1,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int UW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              wr_abort,
    output logic [UW-1:0]     wr_usage,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_commit,
    input  logic              rd_abort,
    output logic [UW-1:0]     rd_usage
);

    logic [PW-1:0] wr_spec, wr_cmt;
    logic [PW-1:0] rd_spec, rd_cmt;
    logic [PW-1:0] wr_occ, rd_avail;
    logic          wr_fire, rd_fire;

    // Occupancy as seen by each side.
    always_comb begin
        wr_occ   = wr_spec - rd_cmt;
        rd_avail = wr_cmt - rd_spec;
    end

    // Handshake and transfer qualifiers.
    always_comb begin
        wr_ready = (wr_occ != PW'(DEPTH));
        rd_valid = (rd_avail != '0);
        wr_fire  = wr_valid && wr_ready;
        rd_fire  = rd_valid && rd_ready;
    end

    assign wr_usage = UW'(wr_occ);
    assign rd_usage = UW'(rd_avail);

    txn_fifo_ptr_pair #(
        .PW     (PW),
        .TXN_EN (WR_TXN)
    ) u_wr_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (wr_fire),
        .commit_i (wr_commit),
        .abort_i  (wr_abort),
        .spec_o   (wr_spec),
        .cmt_o    (wr_cmt)
    );

    txn_fifo_ptr_pair #(
        .PW     (PW),
        .TXN_EN (RD_TXN)
    ) u_rd_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (rd_fire),
        .commit_i (rd_commit),
        .abort_i  (rd_abort),
        .spec_o   (rd_spec),
        .cmt_o    (rd_cmt)
    );

    txn_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_spec[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_spec[AW-1:0]),
        .rdata (rd_data)
    );

endmodule

// File: rtl/txn_fifo_chk.sv
// Property checker for txn_fifo, attached with bind below.
// Observes ports only.
module txn_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter bit WR_TXN = 1'b1,
    parameter bit RD_TXN = 1'b1,
    localparam int UW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_abort,
    input logic [UW-1:0]     wr_usage,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_commit,
    input logic              rd_abort,
    input logic [UW-1:0]     rd_usage
);

    localparam logic [UW-1:0] FULL_U = UW'(DEPTH);

    // R2
    usage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_usage <= FULL_U);

    // R2
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready == (wr_usage != FULL_U));

    // R9
    valid_usage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid == (rd_usage != '0)) && (rd_usage <= wr_usage));

    // R5
    wr_abort_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WR_TXN && wr_abort) |=> (wr_usage <= $past(wr_usage)));

    // R6
    rd_hold_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RD_TXN && !rd_commit && !wr_abort && !(wr_valid && wr_ready))
        |=> (wr_usage == $past(wr_usage)));

    // R11
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !(RD_TXN && rd_abort))
        |=> (rd_valid && $stable(rd_data)));

endmodule

bind txn_fifo txn_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .WR_TXN (WR_TXN),
    .RD_TXN (RD_TXN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_abort  (wr_abort),
    .wr_usage  (wr_usage),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_commit (rd_commit),
    .rd_abort  (rd_abort),
    .rd_usage  (rd_usage)
);

// File: tb/txn_fifo_test.sv
// Directed bench for txn_fifo: one task per scenario.
// Inputs change just after a falling edge; outputs are sampled at falling edges.
module txn_fifo_test;

    localparam int DW = 16;
    localparam int DP = 8;
    localparam int UW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, wr_commit = 1'b0, wr_abort = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_ready = 1'b0, rd_commit = 1'b0, rd_abort = 1'b0;
    logic          wr_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [UW-1:0] wr_usage, rd_usage;

    logic          p_wr_valid = 1'b0, p_wr_commit = 1'b0, p_wr_abort = 1'b0;
    logic [DW-1:0] p_wr_data = '0;
    logic          p_rd_ready = 1'b0, p_rd_commit = 1'b0, p_rd_abort = 1'b0;
    logic          p_wr_ready, p_rd_valid;
    logic [DW-1:0] p_rd_data;
    logic [UW-1:0] p_wr_usage, p_rd_usage;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    txn_fifo #(.DATA_W(DW), .DEPTH(DP), .WR_TXN(1'b1), .RD_TXN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_abort(wr_abort), .wr_usage(wr_usage),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_commit(rd_commit), .rd_abort(rd_abort), .rd_usage(rd_usage)
    );

    txn_fifo #(.DATA_W(DW), .DEPTH(DP), .WR_TXN(1'b0), .RD_TXN(1'b0)) uut_plain (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(p_wr_valid), .wr_ready(p_wr_ready), .wr_data(p_wr_data),
        .wr_commit(p_wr_commit), .wr_abort(p_wr_abort), .wr_usage(p_wr_usage),
        .rd_valid(p_rd_valid), .rd_ready(p_rd_ready), .rd_data(p_rd_data),
        .rd_commit(p_rd_commit), .rd_abort(p_rd_abort), .rd_usage(p_rd_usage)
    );

    function automatic logic [DW-1:0] word(input int k);
        return DW'(16'h3C00 + k * 37);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 0; wr_commit = 0; wr_abort = 0;
        rd_ready = 0; rd_commit = 0; rd_abort = 0;
        p_wr_valid = 0; p_wr_commit = 0; p_wr_abort = 0;
        p_rd_ready = 0; p_rd_commit = 0; p_rd_abort = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [DW-1:0] d, input logic cm);
        wr_valid = 1'b1; wr_data = d; wr_commit = cm;
        @(negedge clk);
        wr_valid = 1'b0; wr_commit = 1'b0;
    endtask

    task automatic pop(input logic [DW-1:0] e, input logic cm, input string tag);
        chk(tag, rd_valid, 1);
        chk(tag, rd_data, e);
        rd_ready = 1'b1; rd_commit = cm;
        @(negedge clk);
        rd_ready = 1'b0; rd_commit = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 wr_usage", wr_usage, 0);
        chk("R1 rd_usage", rd_usage, 0);
    endtask

    task automatic t_basic();
        do_reset();
        for (int i = 0; i < DP; i++) push(word(i), 1'b1);
        chk("R2 full wr_ready", wr_ready, 0);
        chk("R2 full wr_usage", wr_usage, DP);
        chk("R9 rd_usage", rd_usage, DP);
        // extra offer while full must be refused
        push(16'hDEAD, 1'b1);
        chk("R2 refused usage", wr_usage, DP);
        repeat (2) @(negedge clk);
        chk("R11 head held", rd_data, word(0));
        chk("R11 valid held", rd_valid, 1);
        for (int i = 0; i < DP; i++) pop(word(i), 1'b1, "R2 order");
        chk("R2 drained", rd_valid, 0);
        chk("R9 drained usage", wr_usage, 0);
    endtask

    task automatic t_wr_spec();
        do_reset();
        for (int i = 0; i < 3; i++) push(word(10 + i), 1'b0);
        chk("R3 wr_usage", wr_usage, 3);
        chk("R3 rd_usage", rd_usage, 0);
        chk("R3 rd_valid", rd_valid, 0);
        push(word(13), 1'b1);
        chk("R4 rd_usage", rd_usage, 4);
        for (int i = 0; i < 4; i++) pop(word(10 + i), 1'b1, "R4 order");
        chk("R4 drained", rd_valid, 0);
    endtask

    task automatic t_wr_abort();
        do_reset();
        push(word(20), 1'b1);
        push(word(21), 1'b1);
        for (int i = 0; i < 3; i++) push(word(22 + i), 1'b0);
        chk("R5 before", wr_usage, 5);
        // abort together with commit and a transfer offer
        wr_valid = 1'b1; wr_data = 16'hBEEF; wr_commit = 1'b1; wr_abort = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; wr_commit = 1'b0; wr_abort = 1'b0;
        chk("R5 wr_usage", wr_usage, 2);
        chk("R5 rd_usage", rd_usage, 2);
        pop(word(20), 1'b1, "R5 kept");
        pop(word(21), 1'b1, "R5 kept");
        chk("R5 nothing more", rd_valid, 0);
        chk("R5 empty", wr_usage, 0);
    endtask

    task automatic t_rd_txn();
        do_reset();
        for (int i = 0; i < DP; i++) push(word(30 + i), 1'b1);
        for (int i = 0; i < DP; i++) pop(word(30 + i), 1'b0, "R6 read");
        chk("R6 rd_valid", rd_valid, 0);
        chk("R6 wr_ready", wr_ready, 0);
        chk("R6 wr_usage", wr_usage, DP);
        rd_abort = 1'b1;
        @(negedge clk);
        rd_abort = 1'b0;
        chk("R7 rd_usage", rd_usage, DP);
        pop(word(30), 1'b0, "R7 replay");
        pop(word(31), 1'b0, "R7 replay");
        // abort together with a read transfer
        rd_ready = 1'b1; rd_abort = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0; rd_abort = 1'b0;
        chk("R7 rewound head", rd_data, word(30));
        chk("R7 rewound usage", rd_usage, DP);
        pop(word(30), 1'b0, "R8 read");
        pop(word(31), 1'b0, "R8 read");
        pop(word(32), 1'b1, "R8 read");
        chk("R8 wr_usage", wr_usage, DP - 3);
        chk("R8 wr_ready", wr_ready, 1);
        chk("R8 rd_usage", rd_usage, DP - 3);
    endtask

    task automatic t_plain();
        do_reset();
        p_wr_valid = 1'b1; p_wr_data = word(40);
        @(negedge clk);
        p_wr_valid = 1'b0;
        chk("R10 implicit wr commit", p_rd_usage, 1);
        p_wr_valid = 1'b1; p_wr_data = word(41); p_wr_abort = 1'b1;
        @(negedge clk);
        p_wr_valid = 1'b0; p_wr_abort = 1'b0;
        chk("R10 wr abort ignored", p_rd_usage, 2);
        p_rd_ready = 1'b1; p_rd_abort = 1'b1;
        @(negedge clk);
        p_rd_ready = 1'b0; p_rd_abort = 1'b0;
        chk("R10 implicit rd commit", p_wr_usage, 1);
        chk("R10 next head", p_rd_data, word(41));
        p_rd_abort = 1'b1;
        @(negedge clk);
        p_rd_abort = 1'b0;
        chk("R10 rd abort ignored", p_rd_usage, 1);
        chk("R10 head kept", p_rd_data, word(41));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wr_spec();
        t_wr_abort();
        t_rd_txn();
        t_plain();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule